// File: doc/BRIEF.md
# Critical-Word Line Refill Controller

This controller runs the refill of one four-word cache line after a miss. It takes the address of the word the processor is waiting for and the base address of its line. It then fetches the line one word at a time from a memory with fixed latency. Each fetch spends a number of cycles presenting the address, a number of cycles waiting on the array access, and a number of cycles returning the word. The defaults are 4, 56 and 4 cycles, so each fetch takes 64 cycles. The memory is modelled as a source that drives the data for whatever address the controller holds. The controller samples that data in the last return cycle and writes the word into a line buffer.

The processor waits only for the word it asked for. That word is forwarded on a single-cycle port as soon as it has been sampled, while the rest of the line keeps loading. A mode bit chooses the fetch order. With the mode bit at 0, the requested word goes first and the others follow in wrap-around order. With the mode bit at 1, the words are fetched from word 0 upward and the requested word is forwarded when its turn comes. A done pulse marks the end of the fill. A new miss is taken only after that pulse.

The controller has five states: `ST_IDLE`, `ST_ADDR`, `ST_ACCESS`, `ST_XFER` and `ST_DONE`. Its transitions are:
- `ST_IDLE` goes to `ST_ADDR` when a miss is accepted.
- `ST_ADDR` goes to `ST_ACCESS` when the address phase expires.
- `ST_ACCESS` goes to `ST_XFER` when the access phase expires.
- `ST_XFER` goes back to `ST_ADDR` when a word other than the last has been sampled.
- `ST_XFER` goes to `ST_DONE` when the fourth word has been sampled.
- `ST_DONE` goes to `ST_IDLE` after one cycle.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1, and `mem_cmd_valid`, `mem_data_take`, `fwd_valid` and `fill_done` are all 0.
- R2: A miss is accepted on a clock edge where `miss_valid` and `miss_ready` are both 1. `miss_ready` is 0 from the cycle after acceptance through the `fill_done` cycle, and it returns to 1 in the cycle after `fill_done`. A `miss_valid` raised while `miss_ready` is 0 changes neither the fetch addresses nor their timing.
- R3: Counting cycle 1 as the cycle after the acceptance edge, fetch f (f = 0..3) occupies cycles 64f+1 to 64f+64. `mem_cmd_valid` is 1 only in the first 4 cycles of each fetch. `mem_data_take` is 1 only in the 64th cycle of each fetch, and `mem_rdata` is sampled in that cycle.
- R4: With `miss_mode` = 0, fetch f reads word (c + f) mod 4, where c = (`miss_word_addr` − `miss_line_addr`) mod 4.
- R5: With `miss_mode` = 1, fetch f reads word f.
- R6: `fwd_valid` is 1 for exactly one cycle per miss. That cycle is the one after the requested word is sampled: cycle 65 with `miss_mode` = 0, and cycle 64(c+1)+1 with `miss_mode` = 1. In that cycle, `fwd_data` equals the sampled word.
- R7: `fill_done` is 1 only in cycle 257. In that cycle, `line_words[32w+31:32w]` holds the word read from address line+w, for each w.
- R8: For a miss on word 0, both modes give the same address sequence, the same forward cycle and the same done cycle.
- R9: During fetch f, `mem_addr` equals `miss_line_addr` + (word index of that fetch) and stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, miss can be accepted |
| miss_word_addr | input | ADDR_W | Word address the processor needs |
| miss_line_addr | input | ADDR_W | Line base word address (4-aligned) |
| miss_mode | input | 1 | 0: requested word first, wrap; 1: linear from word 0 |
| mem_cmd_valid | output | 1 | Address phase of a fetch |
| mem_addr | output | ADDR_W | Word address of the current fetch |
| mem_data_take | output | 1 | Data sampling cycle of a fetch |
| mem_rdata | input | DATA_W | Memory return data |
| fwd_valid | output | 1 | Requested word forwarded (one cycle) |
| fwd_data | output | DATA_W | Forwarded word |
| fill_done | output | 1 | Whole line loaded (one cycle) |
| line_words | output | WORDS*DATA_W | Line buffer contents, word w in slice w |

## Verification
If the order unit or the sequence count is wrong, the wrong `mem_addr` appears at the first cycle of the affected fetch, so a bad order shows within 65 cycles of acceptance. If the phase timer is wrong, `mem_cmd_valid` or `mem_data_take` moves within a few cycles of the bad phase boundary. A bad forward match shows as a missing, doubled or misplaced `fwd_valid` no later than cycle 257, where the line buffer contents and the done pulse are also compared. Every port is compared in every cycle of each miss, across both modes and all four requested-word positions.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_ACCESS = 3'd2,
        ST_XFER   = 3'd3,
        ST_DONE   = 3'd4
    } cwf_state_e;

    typedef enum logic {
        ORD_CRIT_WRAP = 1'b0,
        ORD_LINEAR    = 1'b1
    } cwf_order_e;

endpackage

// File: rtl/cwf_phase_timer.sv
module cwf_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // load with len-1 so that a phase of len cycles ends with done high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/cwf_fetch_order.sv
module cwf_fetch_order
    import cwf_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  cwf_order_e       order,
    input  logic [IDX_W-1:0] crit,
    input  logic [IDX_W-1:0] seq,
    output logic [IDX_W-1:0] idx
);
    // index arithmetic wraps modulo the line size by its width
    always_comb begin
        unique case (order)
            ORD_CRIT_WRAP: idx = crit + seq;
            ORD_LINEAR:    idx = seq;
            default:       idx = seq;
        endcase
    end
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [WORDS*DATA_W-1:0] line_words
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(w))) begin
                word_q <= wr_data;
            end
        end

        assign line_words[w*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
    import cwf_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int WORDS      = 4,
    parameter int ADDR_CYC   = 4,
    parameter int ACCESS_CYC = 56,
    parameter int XFER_CYC   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    output logic                    miss_ready,
    input  logic [ADDR_W-1:0]       miss_word_addr,
    input  logic [ADDR_W-1:0]       miss_line_addr,
    input  logic                    miss_mode,
    output logic                    mem_cmd_valid,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_data_take,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    fwd_valid,
    output logic [DATA_W-1:0]       fwd_data,
    output logic                    fill_done,
    output logic [WORDS*DATA_W-1:0] line_words
);
    localparam int IDX_W   = $clog2(WORDS);
    localparam int MAX_AB  = (ADDR_CYC > ACCESS_CYC) ? ADDR_CYC : ACCESS_CYC;
    localparam int MAX_LAT = (MAX_AB > XFER_CYC) ? MAX_AB : XFER_CYC;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    cwf_state_e        state_q, state_d;
    cwf_order_e        order_q;
    logic [IDX_W-1:0]  crit_q;
    logic [IDX_W-1:0]  seq_q;
    logic [ADDR_W-1:0] line_q;
    logic [IDX_W-1:0]  fetch_idx;
    logic              fwd_valid_q;
    logic [DATA_W-1:0] fwd_data_q;
    logic              accept;
    logic              last_word;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_done;

    assign accept    = miss_valid && miss_ready;
    assign last_word = (seq_q == IDX_W'(WORDS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (miss_valid) state_d = ST_ADDR;
            ST_ADDR:   if (tmr_done)   state_d = ST_ACCESS;
            ST_ACCESS: if (tmr_done)   state_d = ST_XFER;
            ST_XFER:   if (tmr_done)   state_d = last_word ? ST_DONE : ST_ADDR;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and timer control
    always_comb begin
        miss_ready    = 1'b0;
        mem_cmd_valid = 1'b0;
        mem_data_take = 1'b0;
        fill_done     = 1'b0;
        tmr_load      = 1'b0;
        tmr_len       = CNT_W'(ADDR_CYC);
        unique case (state_q)
            ST_IDLE: begin
                miss_ready = 1'b1;
                tmr_load   = miss_valid;
                tmr_len    = CNT_W'(ADDR_CYC);
            end
            ST_ADDR: begin
                mem_cmd_valid = 1'b1;
                tmr_load      = tmr_done;
                tmr_len       = CNT_W'(ACCESS_CYC);
            end
            ST_ACCESS: begin
                tmr_load = tmr_done;
                tmr_len  = CNT_W'(XFER_CYC);
            end
            ST_XFER: begin
                mem_data_take = tmr_done;
                tmr_load      = tmr_done && !last_word;
                tmr_len       = CNT_W'(ADDR_CYC);
            end
            ST_DONE: begin
                fill_done = 1'b1;
            end
            default: begin
                miss_ready = 1'b0;
            end
        endcase
    end

    // miss capture, fetch sequencing and the forward register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            order_q     <= ORD_CRIT_WRAP;
            crit_q      <= '0;
            seq_q       <= '0;
            line_q      <= '0;
            fwd_valid_q <= 1'b0;
            fwd_data_q  <= '0;
        end else begin
            if (accept) begin
                order_q <= cwf_order_e'(miss_mode);
                crit_q  <= IDX_W'(miss_word_addr - miss_line_addr);
                line_q  <= miss_line_addr;
                seq_q   <= '0;
            end else if (mem_data_take && !last_word) begin
                seq_q <= seq_q + IDX_W'(1);
            end
            fwd_valid_q <= mem_data_take && (fetch_idx == crit_q);
            if (mem_data_take && (fetch_idx == crit_q)) begin
                fwd_data_q <= mem_rdata;
            end
        end
    end

    cwf_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    cwf_fetch_order #(
        .IDX_W (IDX_W)
    ) u_order (
        .order (order_q),
        .crit  (crit_q),
        .seq   (seq_q),
        .idx   (fetch_idx)
    );

    cwf_line_buf #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mem_data_take),
        .wr_idx     (fetch_idx),
        .wr_data    (mem_rdata),
        .line_words (line_words)
    );

    assign mem_addr  = line_q + ADDR_W'(fetch_idx);
    assign fwd_valid = fwd_valid_q;
    assign fwd_data  = fwd_data_q;
endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
    parameter int ADDR_W = 16,
    parameter int WORDS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              mem_cmd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_data_take,
    input logic              fwd_valid,
    input logic              fill_done
);
    localparam int TC_W = $clog2(WORDS + 1);

    logic [TC_W-1:0] take_cnt;
    logic [1:0]      fwd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_cnt <= '0;
            fwd_cnt  <= '0;
        end else if (miss_valid && miss_ready) begin
            take_cnt <= '0;
            fwd_cnt  <= '0;
        end else begin
            if (mem_data_take) take_cnt <= take_cnt + TC_W'(1);
            if (fwd_valid && fwd_cnt != 2'd3) fwd_cnt <= fwd_cnt + 2'd1;
        end
    end

    // R2: busy while fetching, ready again after done
    a_r2_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid || mem_data_take) |-> !miss_ready);
    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);
    a_r2_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> miss_ready);
    // R3: address phase and data sampling never overlap
    a_r3_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_cmd_valid && mem_data_take));
    // R9: address held through the address phase
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && $past(mem_cmd_valid)) |-> $stable(mem_addr));
    // R6: single-cycle forward, exactly one per fill
    a_r6_fwd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !fwd_valid);
    a_r6_fwd_once: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> ((fwd_cnt + {1'b0, fwd_valid}) == 2'd1));
    // R7: done only after every word was sampled, and a single cycle
    a_r7_all_words: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (take_cnt == TC_W'(WORDS)));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);
endmodule

bind cwf_refill_ctrl cwf_refill_chk #(
    .ADDR_W (ADDR_W),
    .WORDS  (WORDS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_addr      (mem_addr),
    .mem_data_take (mem_data_take),
    .fwd_valid     (fwd_valid),
    .fill_done     (fill_done)
);

// File: tb/test_cwf_refill_ctrl.sv
module test_cwf_refill_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic         miss_ready;
    logic [15:0]  miss_word_addr = '0;
    logic [15:0]  miss_line_addr = '0;
    logic         miss_mode = 1'b0;
    logic         mem_cmd_valid;
    logic [15:0]  mem_addr;
    logic         mem_data_take;
    logic [31:0]  mem_rdata;
    logic         fwd_valid;
    logic [31:0]  fwd_data;
    logic         fill_done;
    logic [127:0] line_words;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rec_fwd [2];
    int rec_done [2];
    logic [15:0] rec_addr [2][4];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rd(input logic [15:0] a);
        return {~a, a};
    endfunction

    assign mem_rdata = rd(mem_addr);

    cwf_refill_ctrl i_cwf_refill_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_valid     (miss_valid),
        .miss_ready     (miss_ready),
        .miss_word_addr (miss_word_addr),
        .miss_line_addr (miss_line_addr),
        .miss_mode      (miss_mode),
        .mem_cmd_valid  (mem_cmd_valid),
        .mem_addr       (mem_addr),
        .mem_data_take  (mem_data_take),
        .mem_rdata      (mem_rdata),
        .fwd_valid      (fwd_valid),
        .fwd_data       (fwd_data),
        .fill_done      (fill_done),
        .line_words     (line_words)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                     req, what, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 40000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // one miss, every port compared in every cycle until ready returns
    task automatic run_miss(input int mode, input logic [15:0] line,
                            input int crit, input bit junk);
        int pos;
        pos = (mode == 0) ? 0 : crit;
        @(negedge clk);
        chk("R2", "miss_ready before request", miss_ready, 1);
        miss_valid     = 1'b1;
        miss_mode      = mode[0];
        miss_line_addr = line;
        miss_word_addr = line + 16'(crit);
        for (int t = 1; t <= 258; t++) begin
            int f;
            int ph;
            logic [15:0] e_addr;
            @(negedge clk);
            if (t == 1) begin
                miss_valid     = 1'b0;
                miss_word_addr = 16'hDEAD;
                miss_line_addr = 16'hBEEC;
                miss_mode      = ~mode[0];
            end
            if (junk && t == 100) miss_valid = 1'b1;
            if (junk && t == 121) miss_valid = 1'b0;
            f  = (t - 1) / 64;
            ph = (t - 1) % 64;
            chk("R2", "miss_ready", miss_ready, (t >= 258) ? 1 : 0);
            chk("R3", "mem_cmd_valid", mem_cmd_valid, (t <= 256 && ph < 4) ? 1 : 0);
            chk("R3", "mem_data_take", mem_data_take, (t <= 256 && ph == 63) ? 1 : 0);
            if (t <= 256) begin
                e_addr = line + 16'((mode == 0) ? ((crit + f) % 4) : f);
                chk(mode == 0 ? "R4/R9" : "R5/R9", "mem_addr", mem_addr, e_addr);
                if (crit == 0 && ph == 63) rec_addr[mode][f] = mem_addr;
            end
            chk("R6", "fwd_valid", fwd_valid, (t == 64 * (pos + 1) + 1) ? 1 : 0);
            if (fwd_valid) begin
                chk("R6", "fwd_data", fwd_data, rd(line + 16'(crit)));
                if (crit == 0) rec_fwd[mode] = t;
            end
            chk("R7", "fill_done", fill_done, (t == 257) ? 1 : 0);
            if (fill_done) begin
                if (crit == 0) rec_done[mode] = t;
                chk("R7", "line_words", line_words,
                    {rd(line + 16'd3), rd(line + 16'd2), rd(line + 16'd1), rd(line)});
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "miss_ready", miss_ready, 1);
        chk("R1", "mem_cmd_valid", mem_cmd_valid, 0);
        chk("R1", "mem_data_take", mem_data_take, 0);
        chk("R1", "fwd_valid", fwd_valid, 0);
        chk("R1", "fill_done", fill_done, 0);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
                run_miss(m, 16'h0100 + 16'(64 * (4 * m + c)), c, (c == 2));
            end
        end
        // R8: word-0 misses identical in both modes (line bases differ by 0x100)
        chk("R8", "fwd cycle", rec_fwd[1], rec_fwd[0]);
        chk("R8", "done cycle", rec_done[1], rec_done[0]);
        for (int w = 0; w < 4; w++) begin
            chk("R8", "fetch offset", rec_addr[1][w] - 16'h0100, rec_addr[0][w]);
        end
        finish_run();
    end
endmodule